// File: doc/BRIEF.md
# SPI Serial Controller with Single-Wire Mode

This block moves 8-bit frames over an SPI link as either master or slave. In master mode it generates SCK from the bus clock through a programmable prescaler. The divider counts only while a master transfer is running, so every transfer starts its timing from a fresh count. The block can also drive the slave-select line on its own: low for the whole frame and high between frames. A mode-fault flag reports when another device pulls the select line low while this block is master and is not driving that line itself.

A single-wire option puts all data on one pin. In master mode that pin is MOSI. In slave mode it is MISO. A direction input chooses whether that pin drives or listens. The parallel side takes a byte and a start strobe, and it returns the received byte together with a one-cycle done strobe. Only clock mode 0 is provided. Data is sampled on the rising SCK edge and changes on the falling edge, MSB first.

Top module: `spi_serial_ctrl`

## Requirements
- R1: In master mode, the first rising SCK edge comes (pre_i+1)·2^rate_i bus clocks after the cycle in which start_i is accepted. The SCK period is (pre_i+1)·2^(rate_i+1) bus clocks, and done_o rises 15·(pre_i+1)·2^rate_i clocks after acceptance.
- R2: The prescaler counter is held at zero whenever no master transfer is running. A transfer started after an aborted one therefore keeps the exact R1 timing.
- R3: When ss_oe_o is high, ss_o is low from the cycle after start_i is accepted until the last falling SCK edge, and high otherwise.
- R4: ss_oe_o is high only when en_i, master_i, ss_out_en_i and fault_en_i are all high.
- R5: If en_i, master_i and fault_en_i are high, ss_out_en_i is low, and ss_i is held low, fault_o goes high within four clocks. When ss_out_en_i is high, fault_o stays low.
- R6: In normal master mode (bidir_i=0), data leaves on mosi_o with mosi_oe_o high, is received from miso_i, and miso_oe_o stays low.
- R7: In normal slave mode, data is received from mosi_i. miso_oe_o is high only while ss_i is low, and mosi_oe_o stays low.
- R8: In single-wire master mode (bidir_i=1), mosi is the only data pin: mosi_oe_o equals bidir_oe_i, data is received from mosi_i, and miso_oe_o stays low.
- R9: In single-wire slave mode, miso is the only data pin: miso_oe_o is high only when bidir_oe_i is high and ss_i is low, data is received from miso_i, and mosi_oe_o stays low.
- R10: Frames are MSB first. The first output bit is valid before the first rising SCK edge, input is sampled on rising edges, output changes on falling edges, and SCK idles low.
- R11: done_o is a one-cycle pulse raised at the eighth sampled bit. rx_data_o holds the received byte from that cycle on.
- R12: With en_i low, sck_oe_o, ss_oe_o, mosi_oe_o and miso_oe_o are all low, any transfer is aborted (busy_o low), and start_i is ignored.
- R13: A start_i pulse during a running master transfer is ignored. It does not change that transfer's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| ss_out_en_i | input | 1 | Automatic slave-select output request |
| fault_en_i | input | 1 | Mode-fault enable |
| bidir_i | input | 1 | Single-wire data mode |
| bidir_oe_i | input | 1 | Single-wire pin direction, 1 = drive |
| pre_i | input | PRE_W | Prescaler multiplier field |
| rate_i | input | RATE_W | Prescaler power-of-two field |
| start_i | input | 1 | Load tx_data_i; in master mode, start a frame |
| tx_data_i | input | DATA_W | Byte to send |
| rx_data_o | output | DATA_W | Last received byte |
| done_o | output | 1 | Frame-complete pulse |
| busy_o | output | 1 | Master transfer in progress |
| fault_o | output | 1 | Mode-fault flag |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | SCK drive enable |
| ss_i | input | 1 | Slave-select pin, active low |
| ss_o | output | 1 | Generated slave select |
| ss_oe_o | output | 1 | Slave-select drive enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe_o | output | 1 | MOSI drive enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe_o | output | 1 | MISO drive enable |

## Verification
The hardest case to reach is single-wire operation with the pin turned outward, where the block samples its own driven bit from the shared pin. The bench models the pin by routing the output back to the input whenever the drive enable is high, and by substituting the external device's bit otherwise. A loopback frame must then return the transmitted byte, and a listening frame must return the external byte. Slave-mode frames are clocked slowly enough for the input synchronizers to settle. The abort-then-restart sequence shows that the divider restarts from zero.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  typedef enum logic [1:0] {
    ROLE_M_NORM  = 2'd0,
    ROLE_M_BIDIR = 2'd1,
    ROLE_S_NORM  = 2'd2,
    ROLE_S_BIDIR = 2'd3
  } pin_role_e;

  function automatic pin_role_e role_of(logic master, logic bidir);
    return pin_role_e'({~master, bidir});
  endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int MaxShift = (1 << RATE_W) - 1;
  localparam int CntW     = PRE_W + MaxShift + 1;

  logic [CntW-1:0] cnt_q, half_len;

  // half SCK period = (pre+1) * 2^rate bus clocks
  always_comb half_len = (CntW'(pre_i) + CntW'(1)) << rate_i;
  assign tick_o = run_i && (cnt_q == half_len - CntW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CntW'(1);
  end
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl #(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic master_i,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int Edges = 2 * DATA_W;
  localparam int EdgeW = $clog2(Edges);

  logic [EdgeW-1:0] edge_q;
  logic             busy_q, sck_q;

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign rise_o = busy_q && tick_i && !sck_q;
  assign fall_o = busy_q && tick_i && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      edge_q <= '0;
    end else if (!en_i || !master_i) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      edge_q <= '0;
    end else if (!busy_q) begin
      busy_q <= start_i;
      sck_q  <= 1'b0;
      edge_q <= '0;
    end else if (tick_i) begin
      sck_q <= ~sck_q;
      if (edge_q == EdgeW'(Edges - 1)) begin
        busy_q <= 1'b0;
        edge_q <= '0;
      end else begin
        edge_q <= edge_q + EdgeW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ss_i,
  output logic ss_s_o,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sck_sync_q, ss_sync_q;
  logic                   sck_prev_q;
  logic                   sck_s;

  assign sck_s  = sck_sync_q[SYNC_STAGES-1];
  assign ss_s_o = ss_sync_q[SYNC_STAGES-1];
  assign sel_o  = ~ss_s_o;
  assign rise_o = sel_o && sck_s && !sck_prev_q;
  assign fall_o = sel_o && !sck_s && sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync_q <= '0;
      ss_sync_q  <= '1;
      sck_prev_q <= 1'b0;
    end else begin
      sck_sync_q <= {sck_sync_q[SYNC_STAGES-2:0], sck_i};
      ss_sync_q  <= {ss_sync_q[SYNC_STAGES-2:0], ss_i};
      sck_prev_q <= sck_s;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              done_o
);
  localparam int CntW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, rx_q;
  logic [CntW-1:0]   cnt_q;
  logic              in_q, done_q;

  assign dout_o = sh_q[DATA_W-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      in_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i)      sh_q <= tx_i;
      else if (fall_i) sh_q <= {sh_q[DATA_W-2:0], in_q};
      if (clr_i || load_i) begin
        cnt_q <= '0;
      end else if (rise_i) begin
        in_q <= din_i;
        if (cnt_q == CntW'(DATA_W - 1)) begin
          cnt_q  <= '0;
          rx_q   <= {sh_q[DATA_W-2:0], din_i};
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CntW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_pin_mux.sv
module spi_pin_mux
  import spi_ctrl_pkg::*;
(
  input  logic      en_i,
  input  pin_role_e role_i,
  input  logic      bidir_oe_i,
  input  logic      sel_i,
  input  logic      dout_i,
  input  logic      mosi_i,
  input  logic      miso_i,
  output logic      mosi_o,
  output logic      mosi_oe_o,
  output logic      miso_o,
  output logic      miso_oe_o,
  output logic      din_o
);
  always_comb begin
    mosi_o    = dout_i;
    miso_o    = dout_i;
    mosi_oe_o = 1'b0;
    miso_oe_o = 1'b0;
    din_o     = miso_i;
    unique case (role_i)
      ROLE_M_NORM: begin
        mosi_oe_o = en_i;
        din_o     = miso_i;
      end
      ROLE_M_BIDIR: begin
        mosi_oe_o = en_i & bidir_oe_i;
        din_o     = mosi_i;
      end
      ROLE_S_NORM: begin
        miso_oe_o = en_i & sel_i;
        din_o     = mosi_i;
      end
      ROLE_S_BIDIR: begin
        miso_oe_o = en_i & sel_i & bidir_oe_i;
        din_o     = miso_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_serial_ctrl.sv
module spi_serial_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 3,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              ss_out_en_i,
  input  logic              fault_en_i,
  input  logic              bidir_i,
  input  logic              bidir_oe_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              fault_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic      tick, m_busy, m_sck, m_rise, m_fall;
  logic      s_ss, s_sel, s_rise, s_fall;
  logic      load, clr, rise, fall, dout, din;
  logic      fault_q;
  pin_role_e role;

  assign role = role_of(master_i, bidir_i);

  spi_baud_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_baud (
    .clk_i, .rst_ni, .run_i(m_busy), .pre_i, .rate_i, .tick_o(tick)
  );

  spi_master_ctl #(.DATA_W(DATA_W)) u_mctl (
    .clk_i, .rst_ni, .en_i, .master_i, .start_i, .tick_i(tick),
    .busy_o(m_busy), .sck_o(m_sck), .rise_o(m_rise), .fall_o(m_fall)
  );

  spi_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ss_i,
    .ss_s_o(s_ss), .sel_o(s_sel), .rise_o(s_rise), .fall_o(s_fall)
  );

  // a slave preloads only while deselected; a master only while idle
  assign load = en_i && start_i && (master_i ? !m_busy : !s_sel);
  assign clr  = !en_i || (!master_i && !s_sel);
  assign rise = en_i && (master_i ? m_rise : s_rise);
  assign fall = en_i && (master_i ? m_fall : s_fall);

  spi_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(load), .tx_i(tx_data_i),
    .rise_i(rise), .fall_i(fall), .din_i(din),
    .dout_o(dout), .rx_o(rx_data_o), .done_o
  );

  spi_pin_mux u_pins (
    .en_i, .role_i(role), .bidir_oe_i, .sel_i(s_sel), .dout_i(dout),
    .mosi_i, .miso_i, .mosi_o, .mosi_oe_o, .miso_o, .miso_oe_o, .din_o(din)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= en_i && master_i && fault_en_i && !ss_out_en_i && !s_ss;
  end

  assign busy_o   = m_busy;
  assign fault_o  = fault_q;
  assign sck_o    = m_sck;
  assign sck_oe_o = en_i && master_i;
  assign ss_o     = !m_busy;
  assign ss_oe_o  = en_i && master_i && ss_out_en_i && fault_en_i;
endmodule

// File: rtl/spi_serial_ctrl_chk.sv
module spi_serial_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic ss_out_en_i,
  input logic fault_en_i,
  input logic bidir_i,
  input logic busy_o,
  input logic done_o,
  input logic fault_o,
  input logic sck_o,
  input logic sck_oe_o,
  input logic ss_o,
  input logic ss_oe_o,
  input logic mosi_oe_o,
  input logic miso_oe_o
);
  p_oe_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(sck_oe_o || ss_oe_o || mosi_oe_o || miso_oe_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ss_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_oe_o |-> (master_i && ss_out_en_i && fault_en_i));

  p_ss_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && ss_oe_o) |-> !ss_o);

  p_no_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_out_en_i && $past(ss_out_en_i)) |-> !fault_o);

  p_bidir_m_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && bidir_i) |-> !miso_oe_o);

  p_bidir_s_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !master_i && bidir_i) |-> !mosi_oe_o);

  p_sck_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);

  p_one_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mosi_oe_o, miso_oe_o}));
endmodule

bind spi_serial_ctrl spi_serial_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .master_i(master_i),
  .ss_out_en_i(ss_out_en_i), .fault_en_i(fault_en_i), .bidir_i(bidir_i),
  .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .sck_o(sck_o),
  .sck_oe_o(sck_oe_o), .ss_o(ss_o), .ss_oe_o(ss_oe_o),
  .mosi_oe_o(mosi_oe_o), .miso_oe_o(miso_oe_o)
);

// File: tb/spi_serial_ctrl_test.sv
module spi_serial_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, en, master, ss_out_en, fault_en, bidir, bidir_oe;
  logic [2:0] pre, rate;
  logic       start;
  logic [7:0] tx;
  logic [7:0] rx_data;
  logic       done, busy, fault, sck_in, sck, sck_oe, ss_in, ss, ss_oe;
  logic       mosi_in, mosi, mosi_oe, miso_in, miso, miso_oe;

  logic       slave_tb, tb_mosi, tb_miso;
  logic [7:0] slv_sh;

  int n_chk  = 0;
  int n_fail = 0;

  // external pin model: a driven pin reads back its own value
  assign mosi_in = slave_tb ? tb_mosi : (mosi_oe ? mosi : slv_sh[7]);
  assign miso_in = slave_tb ? (miso_oe ? miso : tb_miso) : slv_sh[7];

  spi_serial_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master),
    .ss_out_en_i(ss_out_en), .fault_en_i(fault_en), .bidir_i(bidir),
    .bidir_oe_i(bidir_oe), .pre_i(pre), .rate_i(rate), .start_i(start),
    .tx_data_i(tx), .rx_data_o(rx_data), .done_o(done), .busy_o(busy),
    .fault_o(fault), .sck_i(sck_in), .sck_o(sck), .sck_oe_o(sck_oe),
    .ss_i(ss_in), .ss_o(ss), .ss_oe_o(ss_oe), .mosi_i(mosi_in),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso_in), .miso_o(miso),
    .miso_oe_o(miso_oe)
  );

  // {pre, rate, bidir, bidir_oe, tx, slave byte, expected rx, half period}
  localparam logic [47:0] VEC [6] = '{
    48'h0000A53C3C01,
    48'h2100817E7E06,
    48'h1011C355C302,
    48'h02100FE1E104,
    48'h7300FF000040,
    48'h400000FFFF05
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic master_run(input logic [47:0] v);
    logic [7:0] got;
    logic [7:0] exp_rx;
    int         half;
    logic       bd, oe;
    got    = '0;
    exp_rx = v[15:8];
    half   = int'(v[7:0]);
    bd     = v[36];
    oe     = v[32];
    @(negedge clk);
    master = 1'b1; bidir = bd; bidir_oe = oe;
    pre = v[46:44]; rate = v[42:40];
    slv_sh = v[23:16]; tx = v[31:24]; start = 1'b1;
    fork
      begin
        int n;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        check(ss == 1'b0, "R3", "ss low at frame start", ss, 0);
        while (!done && n < 5000) begin
          @(negedge clk);
          n++;
        end
        check(done == 1'b1, "R11", "done pulse", done, 1);
        check(rx_data == exp_rx, bd ? "R8" : "R6", "received byte", rx_data, exp_rx);
        check(n == 15 * half, "R1", "clocks to done", n, 15 * half);
        @(negedge clk);
        check(done == 1'b0, "R11", "done one cycle", done, 0);
      end
      begin
        for (int b = 0; b < 8; b++) begin
          logic cap;
          @(posedge sck);
          cap = mosi_in;
          got = {got[6:0], cap};
          if (bd && !oe) check(mosi_oe == 1'b0, "R8", "pin released", mosi_oe, 0);
          if (!bd) check(miso_oe == 1'b0, "R6", "miso undriven", miso_oe, 0);
          @(negedge sck);
          slv_sh = {slv_sh[6:0], cap};
        end
      end
    join
    if (!(bd && !oe)) check(got == v[31:24], "R10", "bits on mosi", got, v[31:24]);
    @(negedge clk);
    check(ss == 1'b1 && busy == 1'b0, "R3", "ss high after frame", ss, 1);
  endtask

  task automatic slave_run(input logic bd, input logic oe, input logic [7:0] t,
                           input logic [7:0] drv, input logic [7:0] exp_rx);
    logic [7:0] got, rxv;
    int         seen;
    got = '0; rxv = '0; seen = 0;
    @(negedge clk);
    slave_tb = 1'b1; master = 1'b0; bidir = bd; bidir_oe = oe;
    ss_in = 1'b1; sck_in = 1'b0; tx = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ss_in = 1'b0;
    repeat (6) @(negedge clk);
    check(mosi_oe == 1'b0, bd ? "R9" : "R7", "mosi undriven in slave", mosi_oe, 0);
    check(miso_oe == (bd ? oe : 1'b1), bd ? "R9" : "R7", "miso drive when selected",
          miso_oe, bd ? oe : 1'b1);
    for (int i = 7; i >= 0; i--) begin
      tb_mosi = drv[i];
      tb_miso = drv[i];
      repeat (8) @(negedge clk);
      got    = {got[6:0], miso};
      sck_in = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (done) begin
          seen++;
          rxv = rx_data;
        end
      end
      sck_in = 1'b0;
    end
    check(seen == 1, "R11", "slave done count", seen, 1);
    check(rxv == exp_rx, bd ? "R9" : "R7", "slave received byte", rxv, exp_rx);
    if (!(bd && !oe)) check(got == t, "R10", "slave bits out", got, t);
    repeat (8) @(negedge clk);
    ss_in = 1'b1;
    repeat (4) @(negedge clk);
    check(miso_oe == 1'b0, "R7", "miso released when deselected", miso_oe, 0);
    slave_tb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; master = 1'b0; ss_out_en = 1'b0; fault_en = 1'b0;
    bidir = 1'b0; bidir_oe = 1'b0; pre = '0; rate = '0; start = 1'b0; tx = '0;
    sck_in = 1'b0; ss_in = 1'b1; slave_tb = 1'b0; tb_mosi = 1'b0; tb_miso = 1'b0;
    slv_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset / disabled state, R12
    check(done == 1'b0, "R11", "done after reset", done, 0);
    check({sck_oe, ss_oe, mosi_oe, miso_oe} == 4'b0, "R12", "oe while disabled",
          {sck_oe, ss_oe, mosi_oe, miso_oe}, 0);
    check(busy == 1'b0 && sck == 1'b0, "R10", "sck idle low", sck, 0);
    check(fault == 1'b0, "R5", "fault after reset", fault, 0);

    // R4: slave-select output gating
    en = 1'b1; master = 1'b1; ss_out_en = 1'b1; fault_en = 1'b0;
    @(negedge clk);
    check(ss_oe == 1'b0, "R4", "ss_oe without fault enable", ss_oe, 0);
    fault_en = 1'b1;
    @(negedge clk);
    check(ss_oe == 1'b1, "R4", "ss_oe fully enabled", ss_oe, 1);
    master = 1'b0;
    @(negedge clk);
    check(ss_oe == 1'b0, "R4", "ss_oe in slave", ss_oe, 0);

    // R5: mode fault
    master = 1'b1; ss_out_en = 1'b0; ss_in = 1'b0;
    repeat (4) @(negedge clk);
    check(fault == 1'b1, "R5", "fault on low ss", fault, 1);
    ss_out_en = 1'b1;
    repeat (4) @(negedge clk);
    check(fault == 1'b0, "R5", "fault masked by ss output", fault, 0);
    ss_in = 1'b1;
    repeat (4) @(negedge clk);

    // table of master frames
    for (int i = 0; i < 6; i++) master_run(VEC[i]);

    // R13: second start during a frame is ignored
    @(negedge clk);
    bidir = 1'b0; pre = 3'd3; rate = 3'd0; slv_sh = 8'hFF; tx = 8'h5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n;
      n = 0;
      while (!done && n < 5000) begin
        @(negedge clk);
        n++;
        if (n == 10) begin
          start = 1'b1; tx = 8'h00;
        end else begin
          start = 1'b0;
        end
      end
      check(n == 60, "R13", "timing unaffected by restart", n, 60);
      check(rx_data == 8'hFF, "R13", "data of busy frame", rx_data, 8'hFF);
    end
    repeat (8) @(negedge clk);

    // R12: abort by disable, start ignored while disabled
    tx = 8'h33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check({sck_oe, ss_oe, mosi_oe, miso_oe} == 4'b0, "R12", "oe after abort",
          {sck_oe, ss_oe, mosi_oe, miso_oe}, 0);
    check(busy == 1'b0, "R12", "busy after abort", busy, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R12", "start ignored while disabled", busy, 0);
    en = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R12", "no frame after enable", busy, 0);

    // R2: fresh divider count after the abort
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n;
      n = 0;
      while (!done && n < 5000) begin
        @(negedge clk);
        n++;
      end
      check(n == 60, "R2", "timing after abort", n, 60);
    end
    repeat (8) @(negedge clk);

    // slave frames: normal, single-wire driving, single-wire listening
    slave_run(1'b0, 1'b0, 8'hB4, 8'h69, 8'h69);
    slave_run(1'b1, 1'b1, 8'h2D, 8'h00, 8'h2D);
    slave_run(1'b1, 1'b0, 8'hF0, 8'h96, 8'h96);

    finish_up();
  end
endmodule